// File: doc/BRIEF.md
# Selectable-Source Clock Divider with Coded Ratio

This block picks one of four clock sources (a reference and three synthesizer outputs) and divides the chosen source by a ratio looked up from a 4-bit code. Everything runs on one system clock. Each source is represented by a one-cycle enable strobe on `src_tick`, and each strobe marks one edge of that source. The divided clock is produced as a level on `clk_data`. A separate drive-enable output, `clk_drive_en`, tells the pad whether to drive `clk_data` or float it.

Two configuration sets are stored. Each set holds a source field and a ratio code. The `alt_sel` pin switches between the two sets while the block is running, with no reprogramming. A power-down request counts only when both the `pd_pin` input and the `cfg_pd_en` bit are high. While it is active, the output is held low.

The divider is a three-state machine:
- **ST_OFF** means powered down.
- **ST_HI** means the output is in its high phase.
- **ST_LO** means the output is in its low phase.

Transitions:
- **Power-down entry:** any state goes to ST_OFF while power-down is active.
- **Restart:** from any running state, or from ST_OFF once power-down is released, a selected edge moves to ST_HI at position 0 if a restart is pending.
- **Phase step:** on each other selected edge, the position advances modulo the ratio. The state becomes ST_HI while the position is below the high length, and ST_LO otherwise.
- **Pulse end:** for ratio 1, ST_HI drops to ST_LO on the first cycle with no selected edge.
- **Wake without edge:** ST_OFF goes to ST_LO when power-down is released and no selected edge arrives in that cycle.

Top module: `clk_route_divider`

## Requirements
- R1: The source field selects the strobe `src_tick[field]`. Field 0 selects the reference, and fields 1, 2 and 3 select synthesizers A, B and C. Strobes of sources that are not selected have no effect on the output.
- R2: Ratio codes 0 through 15 give divide ratios 1, 2, 3, 4, 5, 6, 8, 9, 10, 12, 15, 16, 18, 20, 25 and 50, in that order.
- R3: For a ratio N > 1, each period covers N selected edges. The output is high for the first (N+1)/2 edges of the period, using integer division, and low for the rest. An even N therefore gives a 50% duty cycle. For N = 1, the output is high only in the system cycle that follows each selected edge. The output changes in the cycle after the clock edge at which the strobe is sampled.
- R4: When `pd_pin` and `cfg_pd_en` are both 1, `clk_data` is 0 in that same cycle and stays 0. After power-down is released, the output stays low until the next selected edge, and that edge starts a new period in its high phase.
- R5: When `pd_pin` is 1 and `cfg_pd_en` is 0, the output behaves exactly as if `pd_pin` were 0.
- R6: When `alt_sel` is 0, the set-1 fields (`cfg_src_1`, `cfg_code_1`) are used. When `alt_sel` is 1, the set-2 fields are used. A change of `alt_sel` takes effect on the next cycle with no other action.
- R7: When the selected source or code changes, the next selected edge starts a new period at position 0 in the high phase. From then on the output follows R3 for the new ratio.
- R8: `clk_drive_en` equals `oe_pin`. A value of 0 means the output is floated. `oe_pin` does not affect `clk_data`.
- R9: After reset, `clk_data` is 0 and a restart is pending. With all configuration fields at zero, the output then follows the reference divided by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 4 | One-cycle edge strobes: bit 0 reference, bits 1 to 3 synthesizers A to C |
| cfg_src_1 | input | 2 | Source field for set 1 |
| cfg_code_1 | input | 4 | Ratio code for set 1 |
| cfg_src_2 | input | 2 | Source field for set 2 |
| cfg_code_2 | input | 4 | Ratio code for set 2 |
| cfg_pd_en | input | 1 | Allows `pd_pin` to power the divider down |
| alt_sel | input | 1 | Selects set 2 when 1 |
| pd_pin | input | 1 | Power-down request |
| oe_pin | input | 1 | Output enable |
| clk_data | output | 1 | Divided clock level |
| clk_drive_en | output | 1 | Pad drive enable; 0 floats the output |

## Verification
Some behaviour is checked by assertions on every cycle:
- An active power-down sends the machine to ST_OFF and keeps the output low on the following cycle.
- A selected edge with a restart pending lands in ST_HI at position 0.
- The position holds steady between selected edges.
- A ratio-1 pulse lasts exactly one cycle.

Other behaviour can only be shown by the bench's scenarios, which compare every cycle against a reference model:
- the exact duty-cycle shape for each of the sixteen codes;
- that strobes from sources that are not selected are ignored;
- live switching between the two sets;
- that power-down has no effect when its enable bit is clear.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int SRC_W  = 2;
    localparam int NSRC   = 1 << SRC_W;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 6;
    localparam int KEY_W  = SRC_W + CODE_W;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_HI  = 2'd1,
        ST_LO  = 2'd2
    } div_state_t;

    // Non-linear code to ratio mapping
    function automatic logic [CNT_W-1:0] code_to_ratio(input logic [CODE_W-1:0] c);
        logic [CNT_W-1:0] r;
        unique case (c)
            4'd0:  r = 6'd1;
            4'd1:  r = 6'd2;
            4'd2:  r = 6'd3;
            4'd3:  r = 6'd4;
            4'd4:  r = 6'd5;
            4'd5:  r = 6'd6;
            4'd6:  r = 6'd8;
            4'd7:  r = 6'd9;
            4'd8:  r = 6'd10;
            4'd9:  r = 6'd12;
            4'd10: r = 6'd15;
            4'd11: r = 6'd16;
            4'd12: r = 6'd18;
            4'd13: r = 6'd20;
            4'd14: r = 6'd25;
            default: r = 6'd50;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/src_pick.sv
module src_pick
    import clkdiv_pkg::*;
(
    input  logic              alt_sel,
    input  logic [SRC_W-1:0]  src_1,
    input  logic [CODE_W-1:0] code_1,
    input  logic [SRC_W-1:0]  src_2,
    input  logic [CODE_W-1:0] code_2,
    input  logic [NSRC-1:0]   ticks,
    output logic [SRC_W-1:0]  src_sel,
    output logic [CODE_W-1:0] code_sel,
    output logic              tick_sel
);
    logic [NSRC-1:0] hit;

    always_comb begin
        src_sel  = alt_sel ? src_2  : src_1;
        code_sel = alt_sel ? code_2 : code_1;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_hit
        assign hit[i] = ticks[i] && (src_sel == SRC_W'(i));
    end

    assign tick_sel = |hit;
endmodule

// File: rtl/ratio_lut.sv
module ratio_lut
    import clkdiv_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  ratio,
    output logic [CNT_W-1:0]  high_len
);
    always_comb begin
        ratio    = code_to_ratio(code);
        high_len = (ratio + CNT_W'(1)) >> 1;
    end
endmodule

// File: rtl/div_fsm.sv
module div_fsm
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pd_active,
    input  logic [KEY_W-1:0] key,
    input  logic [CNT_W-1:0] ratio,
    input  logic [CNT_W-1:0] high_len,
    output logic             div_hi
);
    div_state_t       st_q, st_n;
    logic [CNT_W-1:0] pos_q, pos_n, pos_step;
    logic             restart_q, restart_n, restart_now;
    logic [KEY_W-1:0] key_q;

    assign restart_now = restart_q || (key != key_q);
    assign pos_step    = (pos_q >= ratio - CNT_W'(1)) ? '0 : pos_q + CNT_W'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_LO;
            pos_q     <= '0;
            restart_q <= 1'b1;
            key_q     <= '0;
        end else begin
            st_q      <= st_n;
            pos_q     <= pos_n;
            restart_q <= restart_n;
            key_q     <= key;
        end
    end

    // Next state
    always_comb begin
        st_n      = st_q;
        pos_n     = pos_q;
        restart_n = restart_now;
        if (pd_active) begin
            st_n      = ST_OFF;
            pos_n     = '0;
            restart_n = 1'b1;
        end else begin
            unique case (st_q)
                ST_OFF: begin
                    pos_n     = '0;
                    st_n      = tick ? ST_HI : ST_LO;
                    restart_n = !tick;
                end
                ST_HI, ST_LO: begin
                    if (tick) begin
                        if (restart_now) begin
                            pos_n     = '0;
                            st_n      = ST_HI;
                            restart_n = 1'b0;
                        end else begin
                            pos_n = pos_step;
                            st_n  = (pos_step < high_len) ? ST_HI : ST_LO;
                        end
                    end else if (ratio == CNT_W'(1) && st_q == ST_HI) begin
                        st_n = ST_LO;
                    end
                end
                default: begin
                    st_n      = ST_LO;
                    restart_n = 1'b1;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        div_hi = (st_q == ST_HI);
    end

    // R4
    pd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |=> st_q == ST_OFF);

    // R7
    restart_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && restart_now && !pd_active) |=> (st_q == ST_HI && pos_q == '0));

    // R3
    pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio == CNT_W'(1) && st_q == ST_HI && !tick && !pd_active) |=> st_q == ST_LO);

    // R1
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !pd_active && st_q != ST_OFF) |=> $stable(pos_q));
endmodule

// File: rtl/clk_route_divider.sv
module clk_route_divider
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_tick,
    input  logic [SRC_W-1:0]  cfg_src_1,
    input  logic [CODE_W-1:0] cfg_code_1,
    input  logic [SRC_W-1:0]  cfg_src_2,
    input  logic [CODE_W-1:0] cfg_code_2,
    input  logic              cfg_pd_en,
    input  logic              alt_sel,
    input  logic              pd_pin,
    input  logic              oe_pin,
    output logic              clk_data,
    output logic              clk_drive_en
);
    logic [SRC_W-1:0]  src_sel;
    logic [CODE_W-1:0] code_sel;
    logic              tick_sel;
    logic [CNT_W-1:0]  ratio, high_len;
    logic              pd_active;
    logic              div_hi;

    assign pd_active = pd_pin && cfg_pd_en;

    src_pick u_pick (
        .alt_sel  (alt_sel),
        .src_1    (cfg_src_1),
        .code_1   (cfg_code_1),
        .src_2    (cfg_src_2),
        .code_2   (cfg_code_2),
        .ticks    (src_tick),
        .src_sel  (src_sel),
        .code_sel (code_sel),
        .tick_sel (tick_sel)
    );

    ratio_lut u_lut (
        .code     (code_sel),
        .ratio    (ratio),
        .high_len (high_len)
    );

    div_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_sel),
        .pd_active (pd_active),
        .key       ({src_sel, code_sel}),
        .ratio     (ratio),
        .high_len  (high_len),
        .div_hi    (div_hi)
    );

    assign clk_data     = div_hi && !pd_active;
    assign clk_drive_en = oe_pin;

    // R4
    pd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |=> !clk_data);
endmodule

// File: tb/sim_clk_route_divider.sv
`timescale 1ns/1ps
module sim_clk_route_divider;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] src_tick;
    logic [1:0] cfg_src_1, cfg_src_2;
    logic [3:0] cfg_code_1, cfg_code_2;
    logic       cfg_pd_en, alt_sel, pd_pin, oe_pin;
    logic       clk_data, clk_drive_en;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 0;
    string cur_req = "R9";

    // model state
    int       m_pos;
    bit       m_hi, m_rst;
    bit [5:0] m_key;

    always #2.5 clk = ~clk;

    clk_route_divider u0 (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .cfg_src_1(cfg_src_1), .cfg_code_1(cfg_code_1),
        .cfg_src_2(cfg_src_2), .cfg_code_2(cfg_code_2),
        .cfg_pd_en(cfg_pd_en), .alt_sel(alt_sel), .pd_pin(pd_pin),
        .oe_pin(oe_pin), .clk_data(clk_data), .clk_drive_en(clk_drive_en)
    );

    function automatic int ratio_of(input int c);
        case (c)
            0: return 1;   1: return 2;   2: return 3;   3: return 4;
            4: return 5;   5: return 6;   6: return 8;   7: return 9;
            8: return 10;  9: return 12;  10: return 15; 11: return 16;
            12: return 18; 13: return 20; 14: return 25; default: return 50;
        endcase
    endfunction

    function automatic bit exp_data();
        return m_hi && !(pd_pin && cfg_pd_en);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_update();
        int       src, code, n, h;
        bit       tk, rn;
        bit [5:0] key;
        src  = alt_sel ? int'(cfg_src_2)  : int'(cfg_src_1);
        code = alt_sel ? int'(cfg_code_2) : int'(cfg_code_1);
        n    = ratio_of(code);
        h    = (n + 1) / 2;
        tk   = src_tick[src];
        key  = {src[1:0], code[3:0]};
        if (pd_pin && cfg_pd_en) begin
            m_hi = 0; m_pos = 0; m_rst = 1;
        end else begin
            rn = m_rst || (key != m_key);
            if (tk) begin
                if (rn) begin
                    m_pos = 0; m_rst = 0;
                end else begin
                    m_pos = (m_pos >= n - 1) ? 0 : m_pos + 1;
                end
                m_hi = (m_pos < h);
            end else begin
                m_rst = rn;
                if (n == 1) m_hi = 0;
            end
        end
        m_key = key;
    endtask

    // check outputs, then advance one clock
    task automatic cycle();
        #1;
        check(clk_data == exp_data(), cur_req, clk_data, exp_data());
        check(clk_drive_en == oe_pin, "R8", clk_drive_en, oe_pin);
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic rand_ticks(input int sel);
        src_tick = 4'($urandom);
        if (sel >= 0 && ($urandom % 3) != 0) src_tick[sel] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; src_tick = 0; cfg_src_1 = 0; cfg_code_1 = 0;
        cfg_src_2 = 0; cfg_code_2 = 0; cfg_pd_en = 0; alt_sel = 0;
        pd_pin = 0; oe_pin = 1;
        m_pos = 0; m_hi = 0; m_rst = 1; m_key = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(clk_data == 1'b0, "R9", clk_data, 0);
        rst_n = 1;

        // R9: reference divided by 1 after reset
        cur_req = "R9";
        for (int i = 0; i < 40; i++) begin src_tick = 4'($urandom); cycle(); end

        // R1/R2/R3: every code, rotating the source; other strobes random
        for (int c = 0; c < 16; c++) begin
            cur_req = (c % 2 == 0) ? "R2" : "R3";
            cfg_code_1 = 4'(c);
            cfg_src_1  = 2'(c % 4);
            for (int i = 0; i < ratio_of(c) * 6 + 8; i++) begin
                src_tick = 4'($urandom);
                cycle();
            end
        end

        // R1: only non-selected sources toggle; output must not move
        cur_req = "R1";
        cfg_src_1 = 2'd2; cfg_code_1 = 4'd1;
        for (int i = 0; i < 30; i++) begin src_tick = 4'b1011 & 4'($urandom); cycle(); end

        // R6: live switching between sets
        cur_req = "R6";
        cfg_src_2 = 2'd3; cfg_code_2 = 4'd4;
        for (int i = 0; i < 400; i++) begin
            if (i % 37 == 0) alt_sel = ~alt_sel;
            src_tick = 4'($urandom);
            cycle();
        end
        alt_sel = 0;

        // R5: pd pin without enable has no effect
        cur_req = "R5";
        cfg_pd_en = 0; pd_pin = 1;
        for (int i = 0; i < 60; i++) begin src_tick = 4'($urandom); cycle(); end

        // R4: gated power-down and recovery
        cur_req = "R4";
        cfg_pd_en = 1;
        for (int i = 0; i < 30; i++) begin src_tick = 4'($urandom); cycle(); end
        pd_pin = 0;
        for (int i = 0; i < 60; i++) begin src_tick = 4'($urandom); cycle(); end

        // R8: output enable off, data unaffected
        cur_req = "R8";
        oe_pin = 0;
        for (int i = 0; i < 40; i++) begin src_tick = 4'($urandom); cycle(); end
        oe_pin = 1;

        // R7: random mixed reconfiguration
        cur_req = "R7";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 50 == 0) cfg_code_1 = 4'($urandom);
            if ($urandom % 70 == 0) cfg_src_1  = 2'($urandom);
            if ($urandom % 90 == 0) alt_sel    = ~alt_sel;
            if ($urandom % 60 == 0) cfg_code_2 = 4'($urandom);
            if ($urandom % 120 == 0) pd_pin    = ~pd_pin;
            if ($urandom % 150 == 0) oe_pin    = ~oe_pin;
            rand_ticks(-1);
            cycle();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule